// File: doc/BRIEF.md
# Single-Address DMA Block Mover with Boundary Pause

This block moves blocks of bytes between an SD card data path and system memory with a single-address DMA scheme. Software first programs four things: a 32-bit system address, a block size with a 3-bit boundary code, a block count and a transfer-mode word. A write to the start register then launches the transfer. In the read direction the engine takes bytes from the card stream and writes each one to memory. In the write direction it reads each byte from memory and hands it to the card stream.

The address is checked after each byte. When the next address lands on a multiple of the programmed buffer boundary, the engine stops and raises a DMA-boundary status bit. It stays stopped until software writes the system address register again, normally with the value it reads back, which is the next address the engine would use. When the last byte of the last block has been moved, the engine raises a transfer-done status bit. Both status bits are cleared by writing one to them, and they are gated by a status-enable mask.

Top module: `sdma_xfer_engine`

## Requirements
- R1: Register writes use `wr_addr`: 0 system address, 1 block setup (size in bits [11:0], boundary code in [14:12]), 2 block count [15:0], 3 mode, 4 start, 5 status clear, 6 status enable [1:0], 7 host control (DMA select in bits [4:3]). The mode bits are: bit 0 DMA enable, bit 1 count enable, bit 4 direction (1 means card to memory), bit 5 multi-block. A start is ignored, leaving `busy` low and issuing no beats, when DMA enable is clear or the DMA select is not 00.
- R2: In the card-to-memory direction, every accepted card byte becomes one memory write (`mem_we`=1) of that byte, at ascending addresses that begin at the programmed system address.
- R3: In the memory-to-card direction, every memory read (`mem_we`=0) at an ascending address is followed by one card beat that carries the data returned for that read. `sd_tx_data` stays stable while the card does not accept the beat.
- R4: The block count is used only when both count enable and multi-block are set. Otherwise exactly one block is moved.
- R5: A start that selects a block count of zero sets transfer-done at once and moves no bytes.
- R6: The boundary size is 4 KiB shifted left by the code (code 0 is 4 KiB, code 7 is 512 KiB). When the next address is a multiple of that size and the transfer is not finished, the engine pauses. It sets status bit 1, keeps `busy` high, issues no beats, and `sys_addr` shows the next address.
- R7: A write to the system address while paused loads that address and resumes the transfer from it.
- R8: When the last byte of the last block also reaches a boundary, the transfer finishes with done (bit 0) and does not pause.
- R9: Writing status clear resets exactly the status bits written as one. Zero bits leave the status unchanged.
- R10: A status bit whose enable bit is clear is never set. The engine still finishes or pauses as usual.
- R11: A memory request holds its address and direction until `mem_ack`, and each byte is transferred exactly once.
- R12: After reset, `busy`, `status` and `sys_addr` are zero, no request is raised, and both enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| sys_addr | output | 32 | Current or next system address |
| status | output | 2 | Bit 0 transfer done, bit 1 boundary pause |
| busy | output | 1 | Transfer running or paused |
| sd_rx_valid | input | 1 | Card byte available |
| sd_rx_data | input | 8 | Card byte |
| sd_rx_ready | output | 1 | Engine accepts card byte |
| sd_tx_valid | output | 1 | Byte for card available |
| sd_tx_data | output | 8 | Byte for card |
| sd_tx_ready | input | 1 | Card accepts byte |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ack |
| mem_ack | input | 1 | Beat done |

## Verification
A start written in one cycle takes effect at the next rising edge. In the card-to-memory direction the first card byte is taken in the following cycle and the memory request appears the cycle after that. The done bit, the boundary bit, the paused `sys_addr` and the drop of `busy` all change at the same edge that completes the final handshake, and a status clear takes effect at the edge of its write. The bench drives at falling edges and samples results at falling edges after that edge. It polls `busy` and `status` before any end-of-transfer check, while a scoreboard compares each memory and card beat the moment its handshake is seen.

// File: rtl/sdma_xfer_engine.sv
module sdma_xfer_engine #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int SZW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic [AW-1:0] sys_addr,
  output logic [1:0]    status,
  output logic          busy,
  input  logic          sd_rx_valid,
  input  logic [7:0]    sd_rx_data,
  output logic          sd_rx_ready,
  output logic          sd_tx_valid,
  output logic [7:0]    sd_tx_data,
  input  logic          sd_tx_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {S_IDLE, S_CARD, S_MEM, S_SEND, S_PAUSE} st_t;
  st_t state;

  logic [AW-1:0]  addr_q;
  logic [SZW-1:0] blk_size;
  logic [2:0]     bnd_code;
  logic [CW-1:0]  blk_cnt;
  logic           m_dma, m_cnt, m_rd, m_multi;
  logic [1:0]     dsel;
  logic [1:0]     st_en;
  logic [SZW-1:0] byte_cnt;
  logic [CW-1:0]  blk_left;
  logic [7:0]     data_q;
  logic           dir_rd;

  logic [AW-1:0] bmask, next_addr;
  logic [CW-1:0] start_blks;
  logic start_ok, adv, last_byte, last_blk, crosses;
  logic [1:0] st_set, st_clr;

  assign bmask      = (ONE << (5'd12 + {2'b00, bnd_code})) - ONE;
  assign next_addr  = addr_q + ONE;
  assign last_byte  = byte_cnt == blk_size - {{(SZW-1){1'b0}}, 1'b1};
  assign last_blk   = blk_left == {{(CW-1){1'b0}}, 1'b1};
  assign crosses    = (next_addr & bmask) == '0;
  assign start_blks = (m_cnt && m_multi) ? blk_cnt : {{(CW-1){1'b0}}, 1'b1};
  assign start_ok   = wr_en && wr_addr == 3'd4 && m_dma && dsel == 2'b00 && state == S_IDLE;
  assign adv        = (state == S_MEM && mem_ack && dir_rd) || (state == S_SEND && sd_tx_ready);

  assign sys_addr    = addr_q;
  assign busy        = state != S_IDLE;
  assign sd_rx_ready = state == S_CARD;
  assign mem_req     = state == S_MEM;
  assign mem_we      = dir_rd;
  assign mem_addr    = addr_q;
  assign mem_wdata   = data_q;
  assign sd_tx_valid = state == S_SEND;
  assign sd_tx_data  = data_q;

  always_comb begin
    st_set = 2'b00;
    if (start_ok && start_blks == '0) st_set[0] = 1'b1;
    if (adv) begin
      if (last_byte && last_blk) st_set[0] = 1'b1;
      else if (crosses)          st_set[1] = 1'b1;
    end
    st_clr = (wr_en && wr_addr == 3'd5) ? wr_data[1:0] : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_size <= '0;
      bnd_code <= '0;
      blk_cnt  <= '0;
      m_dma    <= 1'b0;
      m_cnt    <= 1'b0;
      m_rd     <= 1'b0;
      m_multi  <= 1'b0;
      dsel     <= 2'b00;
      st_en    <= 2'b11;
      status   <= 2'b00;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          3'd1: begin
            blk_size <= wr_data[SZW-1:0];
            bnd_code <= wr_data[14:12];
          end
          3'd2: blk_cnt <= wr_data[CW-1:0];
          3'd3: begin
            m_dma   <= wr_data[0];
            m_cnt   <= wr_data[1];
            m_rd    <= wr_data[4];
            m_multi <= wr_data[5];
          end
          3'd6: st_en <= wr_data[1:0];
          3'd7: dsel  <= wr_data[4:3];
          default: ;
        endcase
      end
      status <= (status & ~st_clr) | (st_set & st_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      byte_cnt <= '0;
      blk_left <= '0;
      data_q   <= '0;
      dir_rd   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wr_en && wr_addr == 3'd0) addr_q <= wr_data[AW-1:0];
          if (start_ok && start_blks != '0) begin
            blk_left <= start_blks;
            byte_cnt <= '0;
            dir_rd   <= m_rd;
            state    <= m_rd ? S_CARD : S_MEM;
          end
        end
        S_CARD: begin
          if (sd_rx_valid) begin
            data_q <= sd_rx_data;
            state  <= S_MEM;
          end
        end
        S_MEM: begin
          if (mem_ack && !dir_rd) begin
            data_q <= mem_rdata;
            state  <= S_SEND;
          end
        end
        S_PAUSE: begin
          if (wr_en && wr_addr == 3'd0) begin
            addr_q <= wr_data[AW-1:0];
            state  <= dir_rd ? S_CARD : S_MEM;
          end
        end
        default: ;
      endcase
      if (adv) begin
        addr_q <= next_addr;
        if (last_byte) begin
          byte_cnt <= '0;
          blk_left <= blk_left - {{(CW-1){1'b0}}, 1'b1};
        end else begin
          byte_cnt <= byte_cnt + {{(SZW-1){1'b0}}, 1'b1};
        end
        if (last_byte && last_blk) state <= S_IDLE;
        else if (crosses)          state <= S_PAUSE;
        else                       state <= dir_rd ? S_CARD : S_MEM;
      end
    end
  end

endmodule

// File: rtl/sdma_xfer_engine_chk.sv
module sdma_xfer_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [1:0]    status,
  input logic [1:0]    st_en,
  input logic [2:0]    bnd_code,
  input logic [AW-1:0] sys_addr,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          sd_rx_ready,
  input logic          sd_tx_valid,
  input logic          sd_tx_ready,
  input logic [7:0]    sd_tx_data
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  logic [AW-1:0] bnd_mask;
  assign bnd_mask = (ONE << (5'd12 + {2'b00, bnd_code})) - ONE;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sd_tx_valid && !sd_tx_ready |=> sd_tx_valid && $stable(sd_tx_data)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !sd_rx_ready && !sd_tx_valid); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> sys_addr == $past(mem_addr) + ONE); // R2
  AST_MASK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(st_en[0])); // R10
  AST_PAUSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> (sys_addr & bnd_mask) == '0 && busy); // R6
endmodule

bind sdma_xfer_engine sdma_xfer_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .status(status), .st_en(st_en),
  .bnd_code(bnd_code), .sys_addr(sys_addr), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .sd_rx_ready(sd_rx_ready), .sd_tx_valid(sd_tx_valid),
  .sd_tx_ready(sd_tx_ready), .sd_tx_data(sd_tx_data)
);

// File: tb/sdma_xfer_engine_test.sv
`timescale 1ns/1ps
module sdma_xfer_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] sys_addr;
  logic [1:0] status;
  logic busy;
  logic sd_rx_valid = 1'b1;
  logic [7:0] sd_rx_data;
  logic sd_rx_ready;
  logic sd_tx_valid;
  logic [7:0] sd_tx_data;
  logic sd_tx_ready = 1'b1;
  logic mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic mem_ack = 1'b0;

  always #5 clk = ~clk;

  sdma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sys_addr(sys_addr), .status(status), .busy(busy),
    .sd_rx_valid(sd_rx_valid), .sd_rx_data(sd_rx_data), .sd_rx_ready(sd_rx_ready),
    .sd_tx_valid(sd_tx_valid), .sd_tx_data(sd_tx_data), .sd_tx_ready(sd_tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [7:0] rx_cnt = 8'h10;
  assign sd_rx_data = rx_cnt;
  assign mem_rdata  = mem_addr[7:0] ^ 8'hA5;
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (sd_rx_valid && sd_rx_ready) rx_cnt <= rx_cnt + 8'd1;
  end

  typedef struct { logic [31:0] a; logic [7:0] d; logic we; } item_t;
  item_t memq[$];
  logic [7:0] txq[$];
  int checks = 0;
  int errors = 0;
  string tag = "R2";

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (memq.size() == 0) chk(0, {tag, " R11 extra mem beat"}, mem_addr, 32'hFFFFFFFF);
      else begin
        item_t it;
        it = memq.pop_front();
        chk(mem_addr == it.a && mem_we == it.we && (!it.we || mem_wdata == it.d),
            {tag, " mem beat"}, {mem_we, mem_wdata, mem_addr[22:0]}, {it.we, it.d, it.a[22:0]});
      end
    end
    if (rst_n && sd_tx_valid && sd_tx_ready) begin
      if (txq.size() == 0) chk(0, {tag, " R11 extra card beat"}, {24'h0, sd_tx_data}, 32'hFFFFFFFF);
      else begin
        logic [7:0] e;
        e = txq.pop_front();
        chk(sd_tx_data == e, {tag, " R3 card beat"}, {24'h0, sd_tx_data}, {24'h0, e});
      end
    end
  end

  task automatic push_rd(input logic [31:0] a, input int n);
    for (int k = 0; k < n; k++) memq.push_back('{a + k, rx_cnt + 8'(k), 1'b1});
  endtask
  task automatic push_wr(input logic [31:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] x;
      x = a + k;
      memq.push_back('{x, 8'h00, 1'b0});
      txq.push_back(x[7:0] ^ 8'hA5);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 3000; i++) begin
      if (!busy || status[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic queues_empty(input string t);
    chk(memq.size() == 0 && txq.size() == 0, {t, " R11 all beats seen"},
        memq.size() + txq.size(), 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy == 0 && status == 0 && !mem_req && sys_addr == 0, "R12 reset", {busy, status, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 single block because multi is clear
    tag = "R2";
    wr(3'd1, (7 << 12) | 8); wr(3'd2, 5); wr(3'd3, 32'h13); wr(3'd0, 32'h100);
    push_rd(32'h100, 8);
    wr(3'd4, 0); wait_stop();
    chk(status == 2'b01 && !busy, "R4 single block done", {busy, status}, 1);
    chk(sys_addr == 32'h108, "R4 one block only", sys_addr, 32'h108);
    queues_empty("R2");
    wr(3'd5, 3);
    chk(status == 0, "R9 clear both", status, 0);

    // R3 R4 multi-block memory to card
    tag = "R3";
    wr(3'd1, (7 << 12) | 4); wr(3'd2, 3); wr(3'd3, 32'h23); wr(3'd0, 32'h2000);
    push_wr(32'h2000, 12);
    wr(3'd4, 0); wait_stop();
    chk(status == 2'b01 && sys_addr == 32'h200C, "R4 three blocks", sys_addr, 32'h200C);
    queues_empty("R3");
    wr(3'd5, 3);

    // R4 multi set but count enable clear
    tag = "R4";
    wr(3'd3, 32'h31); wr(3'd0, 32'h3000);
    push_rd(32'h3000, 4);
    wr(3'd4, 0); wait_stop();
    chk(sys_addr == 32'h3004 && status == 2'b01, "R4 count disabled", sys_addr, 32'h3004);
    queues_empty("R4");
    wr(3'd5, 3);

    // R6 R7 boundary pause at 4 KiB, then resume
    tag = "R6";
    wr(3'd1, 16); wr(3'd2, 1); wr(3'd3, 32'h13); wr(3'd0, 32'hFF8);
    push_rd(32'hFF8, 8);
    wr(3'd4, 0); wait_stop();
    chk(status == 2'b10 && busy, "R6 paused status", {busy, status}, 32'h6);
    chk(sys_addr == 32'h1000, "R6 next address", sys_addr, 32'h1000);
    repeat (20) @(negedge clk);
    chk(busy && !mem_req && !sd_rx_ready, "R6 no beats while paused", {busy, mem_req, sd_rx_ready}, 32'h4);
    queues_empty("R6");
    wr(3'd5, 0);
    chk(status == 2'b10, "R9 zero write keeps", status, 2);
    wr(3'd5, 2);
    chk(status == 2'b00, "R9 one write clears", status, 0);
    tag = "R7";
    push_rd(32'h1000, 8);
    wr(3'd0, 32'h1000); wait_stop();
    chk(status == 2'b01 && sys_addr == 32'h1008, "R7 resumed and done", sys_addr, 32'h1008);
    queues_empty("R7");
    wr(3'd5, 3);

    // R6 code 1 gives 8 KiB: no pause at 0x1000
    tag = "R6";
    wr(3'd1, (1 << 12) | 8); wr(3'd0, 32'hFFC);
    push_rd(32'hFFC, 8);
    wr(3'd4, 0); wait_stop();
    chk(status == 2'b01 && sys_addr == 32'h1004, "R6 8 KiB code no pause", {status, sys_addr[23:0]}, {2'b01, 24'h1004});
    queues_empty("R6");
    wr(3'd5, 3);

    // R8 last byte lands on boundary
    tag = "R8";
    wr(3'd1, 4); wr(3'd0, 32'h1FFC);
    push_rd(32'h1FFC, 4);
    wr(3'd4, 0); wait_stop();
    chk(status == 2'b01 && !busy && sys_addr == 32'h2000, "R8 done wins", {busy, status}, 1);
    wr(3'd5, 3);

    // R10 done masked
    tag = "R10";
    wr(3'd6, 2); wr(3'd0, 32'h4000);
    push_rd(32'h4000, 4);
    wr(3'd4, 0); wait_stop();
    chk(!busy && status == 0, "R10 masked done", {busy, status}, 0);
    queues_empty("R10");
    wr(3'd6, 3);

    // R1 ignored starts
    tag = "R1";
    wr(3'd3, 32'h12); wr(3'd4, 0);
    @(negedge clk);
    chk(!busy && status == 0 && sys_addr == 32'h4004, "R1 DMA enable clear", {busy, status}, 0);
    wr(3'd3, 32'h13); wr(3'd7, 2 << 3); wr(3'd4, 0);
    @(negedge clk);
    chk(!busy && !mem_req && !sd_rx_ready, "R1 select not 00", {busy, mem_req, sd_rx_ready}, 0);
    wr(3'd7, 0);

    // R5 zero block count
    tag = "R5";
    wr(3'd3, 32'h33); wr(3'd2, 0); wr(3'd4, 0);
    chk(status == 2'b01 && !busy && sys_addr == 32'h4004, "R5 zero count", {busy, status}, 1);
    queues_empty("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule